// File: doc/BRIEF.md
# Zero-Extending Word Load Unit

This unit executes the four zero-extending 32-bit word loads of a 64-bit big-endian processor. It takes one instruction word per issue and reads the base and index registers through a combinational register-file read port. It then forms a 32-bit effective address and fetches the word from a byte-addressed memory through a request/response port. When it finishes, it reports the result in a single done cycle. That cycle carries up to two register writes: the loaded value to the destination, and, for the update forms, the effective address back to the base register.

The memory port only serves aligned 32-bit words. A load whose address is not a multiple of four is split into two aligned beats, and the unit assembles the word from the bytes of both beats. No alignment fault is ever raised. Encodings the unit does not recognise, and update forms with a forbidden base register, complete through the same done cycle. In those cases a flag is raised, and no memory access or register write takes place.

Top module: `wordload_unit`

## Requirements
- R1: Bit 31 of `insn` is the most significant bit. The primary opcode is `insn[31:26]`, the destination is `insn[25:21]`, the base is `insn[20:16]` and the 16-bit displacement is `insn[15:0]`. Primary opcode 32 loads from base plus displacement.
- R2: Primary opcode 33 loads like opcode 32. It also writes the 32-bit effective address, zero-extended, to the base register on the second write port (`wr1`).
- R3: Primary opcode 31 uses the register at `insn[15:11]` as the index instead of the displacement. The extended opcode is taken from `insn[10:1]`. Extended opcode 23 is the plain indexed load, and extended opcode 55 is the indexed load with the base update of R2.
- R4: In the two non-update forms, a base field of 0 contributes the value zero, whatever register 0 holds. The update forms always use the register value.
- R5: The displacement is sign-extended before it is added. The sum is truncated to 32 bits, so addresses wrap modulo 2^32.
- R6: The byte at the effective address becomes bits 31:24 of the result, and the next three bytes follow in order. The destination write (`wr0`) carries this value with bits 63:32 zero.
- R7: An aligned load uses one memory beat. A load with a nonzero `EA[1:0]` uses two beats, first at `EA & ~3` and then at the next word. Every request address has bits 1:0 equal to zero, and no alignment fault exists.
- R8: An update form whose base field is 0, or whose base field equals its destination field, raises `bad_form` in the done cycle. It makes no memory request and no register write.
- R9: Any primary opcode other than 31, 32 or 33, and opcode 31 with an extended opcode other than 23 or 55, raise `illegal` in the done cycle. Such an encoding makes no memory request and no register write.
- R10: `done` is high for exactly one cycle per issued instruction. The write enables, indices and data are valid in that cycle.
- R11: A memory request is held, with a stable address, until `mem_req_ready` accepts it. At most one beat is outstanding, so no request is raised while a response is awaited.
- R12: `issue_ready` is high only when the unit is idle. It is low from the cycle after an accepted issue until `done` has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is offered |
| issue_ready | output | 1 | The unit is idle and accepts `insn` |
| insn | input | 32 | Instruction word |
| rf_a_addr | output | 5 | Base register number, taken from `insn` |
| rf_a_data | input | 64 | Base register value |
| rf_b_addr | output | 5 | Index register number, taken from `insn` |
| rf_b_data | input | 64 | Index register value |
| mem_req_valid | output | 1 | Aligned word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word-aligned byte address |
| mem_rsp_valid | input | 1 | Read data is returned |
| mem_rsp_data | input | 32 | Big-endian word, lowest-address byte in bits 31:24 |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unrecognised encoding (with `done`) |
| bad_form | output | 1 | Invalid update form (with `done`) |
| wr0_en | output | 1 | Destination write enable |
| wr0_idx | output | 5 | Destination register number |
| wr0_data | output | 64 | Loaded word, zero-extended |
| wr1_en | output | 1 | Base update write enable |
| wr1_idx | output | 5 | Base register number |
| wr1_data | output | 64 | Effective address, zero-extended |

## Verification
The memory model returns a distinct byte at every address, so a wrong byte order, a wrong beat or a wrong offset changes the loaded value. Each of the four forms is issued with aligned and unaligned addresses, and the bench counts the memory beats of every load. A base field of 0 is tried while register 0 holds a nonzero value, which shows whether the literal zero or the register is used. Negative displacements and a base near 2^64 show whether sign extension and the 32-bit wrap are applied. Invalid update forms and unknown opcodes are checked for zero beats and zero writes, and a stalling memory shows that the request is held until it is accepted.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam int INSN_W = 32;
  localparam int REG_W  = 64;
  localparam int ADDR_W = 32;
  localparam int RIDX_W = 5;

  localparam logic [5:0] OP_INDEXED  = 6'd31;
  localparam logic [5:0] OP_DISP     = 6'd32;
  localparam logic [5:0] OP_DISP_UPD = 6'd33;
  localparam logic [9:0] XO_IDX      = 10'd23;
  localparam logic [9:0] XO_IDX_UPD  = 10'd55;

  typedef struct packed {
    logic              legal;
    logic              upd;
    logic              indexed;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
    logic [15:0]       disp;
  } wl_dec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} wl_state_e;

  function automatic logic [REG_W-1:0] wl_sext16(input logic [15:0] v);
    return {{(REG_W-16){v[15]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] wl_ea(input logic [REG_W-1:0] base,
                                              input logic [REG_W-1:0] off);
    logic [REG_W-1:0] sum;
    sum = base + off;
    return sum[ADDR_W-1:0];
  endfunction

  // Bytes of {first, second} starting at byte offset 'off', big-endian.
  function automatic logic [31:0] wl_pick(input logic [31:0] first,
                                          input logic [31:0] second,
                                          input logic [1:0]  off);
    logic [63:0] pair;
    pair = {first, second} << {off, 3'b000};
    return pair[63:32];
  endfunction
endpackage

// File: rtl/wl_decode.sv
module wl_decode
  import wl_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output wl_dec_t           dec
);
  logic [5:0] op;
  logic [9:0] xo;

  assign op = insn[31:26];
  assign xo = insn[10:1];

  always_comb begin
    dec         = '0;
    dec.rd      = insn[25:21];
    dec.ra      = insn[20:16];
    dec.rb      = insn[15:11];
    dec.disp    = insn[15:0];
    unique case (op)
      OP_DISP:     dec.legal = 1'b1;
      OP_DISP_UPD: begin dec.legal = 1'b1; dec.upd = 1'b1; end
      OP_INDEXED: begin
        if (xo == XO_IDX) begin
          dec.legal = 1'b1; dec.indexed = 1'b1;
        end else if (xo == XO_IDX_UPD) begin
          dec.legal = 1'b1; dec.indexed = 1'b1; dec.upd = 1'b1;
        end
      end
      default: dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/wl_agen.sv
module wl_agen
  import wl_pkg::*;
(
  input  wl_dec_t           dec,
  input  logic [REG_W-1:0]  a_data,
  input  logic [REG_W-1:0]  b_data,
  output logic [ADDR_W-1:0] ea
);
  logic [REG_W-1:0] base;
  logic [REG_W-1:0] off;

  assign base = (dec.ra == '0 && !dec.upd) ? '0 : a_data;
  assign off  = dec.indexed ? b_data : wl_sext16(dec.disp);
  assign ea   = wl_ea(base, off);
endmodule

// File: rtl/wl_merge.sv
module wl_merge
  import wl_pkg::*;
(
  input  logic [31:0] first_word,
  input  logic [31:0] second_word,
  input  logic [1:0]  byte_off,
  output logic [31:0] word
);
  assign word = wl_pick(first_word, second_word, byte_off);
endmodule

// File: rtl/wordload_unit.sv
module wordload_unit
  import wl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [31:0]       insn,
  output logic [4:0]        rf_a_addr,
  input  logic [63:0]       rf_a_data,
  output logic [4:0]        rf_b_addr,
  input  logic [63:0]       rf_b_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              done,
  output logic              illegal,
  output logic              bad_form,
  output logic              wr0_en,
  output logic [4:0]        wr0_idx,
  output logic [63:0]       wr0_data,
  output logic              wr1_en,
  output logic [4:0]        wr1_idx,
  output logic [63:0]       wr1_data
);
  localparam int PAD_W = REG_W - ADDR_W;

  wl_dec_t           dec;
  logic [ADDR_W-1:0] ea_now;
  wl_state_e         st;
  logic [ADDR_W-1:0] ea_q;
  logic [4:0]        rd_q, ra_q;
  logic              upd_q, illegal_q, badform_q, beat_q;
  logic [31:0]       w0_q, w1_q, merged;

  // named events for the checker
  logic issue_fire, rsp_wait, unaligned, form_bad;

  wl_decode u_dec (.insn(insn), .dec(dec));
  wl_agen   u_agen (.dec(dec), .a_data(rf_a_data), .b_data(rf_b_data), .ea(ea_now));
  wl_merge  u_merge (.first_word(w0_q), .second_word(w1_q),
                     .byte_off(ea_q[1:0]), .word(merged));

  assign rf_a_addr   = dec.ra;
  assign rf_b_addr   = dec.rb;
  assign issue_ready = (st == ST_IDLE);
  assign issue_fire  = issue_valid && issue_ready;
  assign rsp_wait    = (st == ST_WAIT);
  assign unaligned   = (ea_q[1:0] != 2'b00);
  assign form_bad    = dec.upd && (dec.ra == '0 || dec.ra == dec.rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ea_q      <= '0;
      rd_q      <= '0;
      ra_q      <= '0;
      upd_q     <= 1'b0;
      illegal_q <= 1'b0;
      badform_q <= 1'b0;
      beat_q    <= 1'b0;
      w0_q      <= '0;
      w1_q      <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (issue_fire) begin
          ea_q      <= ea_now;
          rd_q      <= dec.rd;
          ra_q      <= dec.ra;
          upd_q     <= dec.upd;
          illegal_q <= !dec.legal;
          badform_q <= dec.legal && form_bad;
          beat_q    <= 1'b0;
          st        <= (!dec.legal || form_bad) ? ST_DONE : ST_REQ;
        end
        ST_REQ: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (!beat_q) w0_q <= mem_rsp_data;
          else         w1_q <= mem_rsp_data;
          if (!beat_q && unaligned) begin
            beat_q <= 1'b1;
            st     <= ST_REQ;
          end else begin
            st <= ST_DONE;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st == ST_REQ);
  assign mem_req_addr  = {ea_q[ADDR_W-1:2], 2'b00} + (beat_q ? 32'd4 : 32'd0);

  assign done     = (st == ST_DONE);
  assign illegal  = done && illegal_q;
  assign bad_form = done && badform_q;
  assign wr0_en   = done && !illegal_q && !badform_q;
  assign wr0_idx  = rd_q;
  assign wr0_data = {{PAD_W{1'b0}}, merged};
  assign wr1_en   = wr0_en && upd_q;
  assign wr1_idx  = ra_q;
  assign wr1_data = {{PAD_W{1'b0}}, ea_q};
endmodule

// File: rtl/wl_checker.sv
module wl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        issue_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        rsp_wait,
  input logic        done,
  input logic        illegal,
  input logic        bad_form,
  input logic        wr0_en,
  input logic [4:0]  wr0_idx,
  input logic [63:0] wr0_data,
  input logic        wr1_en,
  input logic [4:0]  wr1_idx
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_badform_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_form |-> (done && !wr0_en && !wr1_en));

  assert_illegal_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !wr0_en && !wr1_en));

  assert_update_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |-> (wr0_en && wr1_idx != 5'd0 && wr1_idx != wr0_idx));

  assert_zero_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr0_en |-> (wr0_data[63:32] == 32'd0));

  assert_aligned_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_wait);

  assert_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || rsp_wait || done) |-> !issue_ready);
endmodule

bind wordload_unit wl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .issue_ready(issue_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .rsp_wait(rsp_wait), .done(done),
  .illegal(illegal), .bad_form(bad_form), .wr0_en(wr0_en),
  .wr0_idx(wr0_idx), .wr0_data(wr0_data), .wr1_en(wr1_en), .wr1_idx(wr1_idx)
);

// File: tb/sim_wordload_unit.sv
`timescale 1ns/1ps
module sim_wordload_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [31:0] insn = '0;
  logic [4:0]  rf_a_addr, rf_b_addr;
  logic [63:0] rf_a_data, rf_b_data;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, illegal, bad_form, wr0_en, wr1_en;
  logic [4:0]  wr0_idx, wr1_idx;
  logic [63:0] wr0_data, wr1_data;

  logic [63:0] regs [32];
  logic        stall_mode = 1'b0;
  int unsigned cyc = 0;
  int unsigned req_count = 0;
  int          checks = 0;
  int          failures = 0;

  always #2 clk = ~clk;

  assign rf_a_data     = regs[rf_a_addr];
  assign rf_b_data     = regs[rf_b_addr];
  assign mem_req_ready = !stall_mode || (cyc % 3 == 0);

  wordload_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .insn(insn), .rf_a_addr(rf_a_addr), .rf_a_data(rf_a_data),
    .rf_b_addr(rf_b_addr), .rf_b_data(rf_b_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .illegal(illegal),
    .bad_form(bad_form), .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_data(wr1_data)
  );

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C ^ {a[1:0], 6'd0};
  endfunction

  function automatic logic [31:0] mword_be(input logic [31:0] a);
    return {mbyte(a), mbyte(a + 32'd1), mbyte(a + 32'd2), mbyte(a + 32'd3)};
  endfunction

  // memory model: one-cycle response to an accepted aligned request
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mword_be(mem_req_addr);
      req_count     <= req_count + 1;
    end
  end

  function automatic logic [31:0] enc_d(input int op, input int rd, input int ra,
                                        input logic [15:0] d);
    return {op[5:0], rd[4:0], ra[4:0], d};
  endfunction

  function automatic logic [31:0] enc_x(input int xo, input int rd, input int ra,
                                        input int rb);
    return {6'd31, rd[4:0], ra[4:0], rb[4:0], xo[9:0], 1'b0};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // err: 0 none, 1 illegal, 2 bad form
  task automatic run(input logic [31:0] word, input int err, input bit upd,
                     input int rd, input int ra, input logic [31:0] ea,
                     input string tag);
    int unsigned base_cnt;
    int waited;
    int beats;
    logic [63:0] exp_val;
    @(negedge clk);
    base_cnt    = req_count;
    insn        = word;
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
    check(issue_ready == 1'b0 || done, {tag, " R12 busy after issue"},
          {63'd0, issue_ready}, 64'd0);
    waited = 0;
    while (!done && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, {tag, " R10 done seen"}, {63'd0, done}, 64'd1);
    beats   = int'(req_count - base_cnt);
    exp_val = {32'd0, mword_be(ea)};
    if (err == 1) begin
      check(illegal && !wr0_en && !wr1_en && !bad_form, {tag, " R9 illegal no write"},
            {60'd0, illegal, bad_form, wr0_en, wr1_en}, 64'h8);
      check(beats == 0, {tag, " R9 no beats"}, 64'(beats), 64'd0);
    end else if (err == 2) begin
      check(bad_form && !wr0_en && !wr1_en && !illegal, {tag, " R8 bad form no write"},
            {60'd0, illegal, bad_form, wr0_en, wr1_en}, 64'h4);
      check(beats == 0, {tag, " R8 no beats"}, 64'(beats), 64'd0);
    end else begin
      check(wr0_en && !illegal && !bad_form && wr0_idx == rd[4:0],
            {tag, " R1 dest write"}, {54'd0, wr0_en, illegal, bad_form, wr0_idx},
            {54'd0, 1'b1, 2'b00, rd[4:0]});
      check(wr0_data == exp_val, {tag, " R6 loaded value"}, wr0_data, exp_val);
      check(wr1_en == upd, {tag, " R2 update enable"}, {63'd0, wr1_en}, {63'd0, upd});
      if (upd)
        check(wr1_idx == ra[4:0] && wr1_data == {32'd0, ea}, {tag, " R2 base update"},
              wr1_data, {32'd0, ea});
      check(beats == ((ea[1:0] != 2'b00) ? 2 : 1), {tag, " R7 beat count"},
            64'(beats), (ea[1:0] != 2'b00) ? 64'd2 : 64'd1);
    end
    @(negedge clk);
    check(!done && issue_ready, {tag, " R10 single-cycle done"},
          {62'd0, done, issue_ready}, 64'd1);
  endtask

  task automatic t_reset();
    check(!done && !mem_req_valid && issue_ready && !wr0_en && !wr1_en,
          "R10 reset state", {59'd0, done, mem_req_valid, issue_ready, wr0_en, wr1_en},
          64'h4);
  endtask

  task automatic t_plain();
    run(enc_d(32, 3, 5, 16'h0010), 0, 0, 3, 5, 32'h0000_1010, "R1 aligned plain");
    run(enc_d(32, 4, 5, 16'h0011), 0, 0, 4, 5, 32'h0000_1011, "R1 offset1");
  endtask

  task automatic t_zero_base();
    run(enc_d(32, 3, 0, 16'h0204), 0, 0, 3, 0, 32'h0000_0204, "R4 literal zero disp");
    run(enc_x(23, 2, 0, 8), 0, 0, 2, 0, 32'h0000_3002, "R4 literal zero indexed");
  endtask

  task automatic t_sext_wrap();
    run(enc_d(32, 7, 5, 16'hFFF8), 0, 0, 7, 5, 32'h0000_0FF8, "R5 negative disp");
    run(enc_d(32, 7, 6, 16'h0023), 0, 0, 7, 6, 32'h0000_0013, "R5 wrap");
  endtask

  task automatic t_update();
    run(enc_d(33, 7, 6, 16'h0013), 0, 1, 7, 6, 32'h0000_0003, "R2 disp update");
    run(enc_d(33, 9, 1, 16'h0000), 0, 1, 9, 1, 32'h0000_0000, "R4 update reads r-base");
  endtask

  task automatic t_indexed();
    run(enc_x(23, 3, 5, 8), 0, 0, 3, 5, 32'h0000_4002, "R3 indexed");
    run(enc_x(55, 9, 10, 8), 0, 1, 9, 10, 32'h0000_3103, "R3 indexed update");
  endtask

  task automatic t_invalid();
    run(enc_d(33, 4, 0, 16'h0010), 2, 0, 4, 0, 32'd0, "R8 update base zero");
    run(enc_x(55, 10, 10, 8), 2, 0, 10, 10, 32'd0, "R8 update base equals dest");
    run(enc_d(34, 4, 5, 16'h0010), 1, 0, 4, 5, 32'd0, "R9 opcode 34");
    run(enc_x(24, 4, 5, 8), 1, 0, 4, 5, 32'd0, "R9 xo 24");
  endtask

  task automatic t_stall();
    stall_mode = 1'b1;
    run(enc_d(32, 3, 5, 16'h0016), 0, 0, 3, 5, 32'h0000_1016, "R11 stalled unaligned");
    run(enc_x(55, 9, 10, 11), 0, 1, 9, 10, 32'h0000_0180, "R11 stalled aligned update");
    stall_mode = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'hA5A5_0000_0000_0000 + 64'(i * 16'h0111);
    regs[0]  = 64'h0000_0000_0000_7770;
    regs[1]  = 64'h0000_0000_0000_0000;
    regs[5]  = 64'hDEAD_BEEF_0000_1000;
    regs[6]  = 64'hFFFF_FFFF_FFFF_FFF0;
    regs[8]  = 64'h0000_0000_0000_3002;
    regs[10] = 64'h0000_0000_0000_0101;
    regs[11] = 64'h0000_0000_0000_007F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_zero_base();
    t_sext_wrap();
    t_update();
    t_indexed();
    t_invalid();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule